// File: doc/BRIEF.md
# Interleaved Region and Bank Router

This block sits where a node's first-level crossbar turns a request into a slave choice. It takes a 44-bit physical address and names one of six slaves: four shared cache banks or one of two I/O link controllers. The three top address bits pick the region. Requests that land in the cache region are spread over the banks by one pair of address bits.

A small select register decides which pair of address bits does the interleaving. Software can rewrite that register while traffic is flowing, which lets it change the interleave granularity at run time. The decision is registered, so the route appears one cycle after the request and is qualified by an output valid. Requests to the unmapped region codes produce a single-cycle error pulse and select no slave.

Top module: `addr_route_xbar`

## Requirements
- R1: During reset and right after it, route_valid, decode_err, route_sel and bank_idx are 0. The select register holds 0, and reading it returns 0.
- R2: When the request address has bits [43:41] equal to 0, 1, 2 or 3 and req_valid is 1, the next cycle shows route_valid=1 and a one-hot route_sel with only bit b set, where b is the bank index. bank_idx shows b in the same cycle.
- R3: A request with bits [43:41]=6 gives route_sel bit 4 (link 0) on the next cycle. A request with bits [43:41]=7 gives bit 5 (link 1). In both cases route_valid=1 and bank_idx=0.
- R4: A request with bits [43:41] equal to 4 or 5 raises decode_err for exactly one cycle on the next cycle. In that cycle route_valid=0 and route_sel=0.
- R5: With select value n in the register, the bank index of a cache request is address bits [7+2n:6+2n]. This runs from [7:6] for n=0 to [37:36] for n=15, and n is 0 after reset.
- R6: A write with cfg_wr_en=1 and cfg_addr=0x3FF00400 changes the select value from the next cycle on. A request presented in the same cycle as the write is still decoded with the old value.
- R7: A write keeps only cfg_wdata[3:0]. Writes to any other cfg_addr leave the select value unchanged. cfg_rdata returns the select value zero-extended to 32 bits while cfg_addr=0x3FF00400, and 0 for any other address.
- R8: A cycle with req_valid=0 gives route_valid=0, decode_err=0, route_sel=0 and bank_idx=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request address is valid |
| req_addr | input | 44 | Physical request address |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_addr | input | 32 | Register access address |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, zero-extended select value |
| route_valid | output | 1 | Route outputs hold a decoded request |
| route_sel | output | 6 | One-hot slave select: bits 0..3 are banks, bit 4 is link 0, bit 5 is link 1 |
| bank_idx | output | 2 | Cache bank number, 0 for requests outside the cache region |
| decode_err | output | 1 | One-cycle pulse for an unmapped region |

## Verification
A select register with a corrupted value shows up on the very next cache request as a wrong bank_idx and a wrong route_sel bit. It is also visible at once on cfg_rdata. For this reason, every program of the register is followed by requests whose addresses have different values in each candidate bit pair. A write applied one cycle early or late would misroute the request presented alongside it, so that exact case is checked. A misdecoded region code shows up on the next cycle as the wrong slave bit or a missing error pulse.

// File: rtl/arx_pkg.sv
package arx_pkg;
   typedef enum logic [1:0] {
      DST_NONE  = 2'd0,
      DST_CACHE = 2'd1,
      DST_LINK0 = 2'd2,
      DST_LINK1 = 2'd3
   } dest_e;
endpackage

// File: rtl/arx_region_decode.sv
module arx_region_decode
   import arx_pkg::*;
#(
   parameter int REGION_W       = 3,
   parameter int CACHE_CODE_CNT = 4,
   parameter int LINK0_CODE     = 6,
   parameter int LINK1_CODE     = 7
) (
   input  logic [REGION_W-1:0] region,
   output dest_e               dest
);
   always_comb begin
      if (int'(region) < CACHE_CODE_CNT)
         dest = DST_CACHE;
      else if (int'(region) == LINK0_CODE)
         dest = DST_LINK0;
      else if (int'(region) == LINK1_CODE)
         dest = DST_LINK1;
      else
         dest = DST_NONE;
   end
endmodule

// File: rtl/arx_bank_pick.sv
module arx_bank_pick #(
   parameter int ADDR_W    = 44,
   parameter int SEL_W     = 4,
   parameter int BANK_W    = 2,
   parameter int BANK_BASE = 6
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [SEL_W-1:0]  sel,
   output logic [BANK_W-1:0] bank
);
   localparam int OPT_CNT = 2 ** SEL_W;

   logic unused_addr_bits;
   assign unused_addr_bits = ^addr;

   generate
      if (SEL_W == 0) begin : g_fixed
         logic unused_sel;
         assign unused_sel = ^sel;
         assign bank = addr[BANK_BASE +: BANK_W];
      end else begin : g_prog
         logic [BANK_W-1:0] cand [OPT_CNT];
         for (genvar i = 0; i < OPT_CNT; i++) begin : g_opt
            assign cand[i] = addr[BANK_BASE + i*BANK_W +: BANK_W];
         end
         assign bank = cand[sel];
      end
   endgenerate
endmodule

// File: rtl/arx_sel_reg.sv
module arx_sel_reg #(
   parameter int          CFG_AW   = 32,
   parameter int          CFG_DW   = 32,
   parameter int          SEL_W    = 4,
   parameter logic [31:0] CFG_ADDR = 32'h3FF0_0400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [CFG_AW-1:0] addr,
   input  logic [CFG_DW-1:0] wdata,
   output logic [SEL_W-1:0]  sel_q,
   output logic [CFG_DW-1:0] rdata
);
   logic hit;
   assign hit = (addr == CFG_AW'(CFG_ADDR));

   logic unused_wdata;
   assign unused_wdata = ^wdata;

   always_ff @(posedge clk) begin
      if (!rst_n)
         sel_q <= '0;
      else if (wr_en && hit)
         sel_q <= wdata[SEL_W-1:0];
   end

   assign rdata = hit ? CFG_DW'(sel_q) : '0;
endmodule

// File: rtl/addr_route_xbar.sv
module addr_route_xbar
   import arx_pkg::*;
#(
   parameter int          ADDR_W         = 44,
   parameter int          REGION_W       = 3,
   parameter int          NUM_BANKS      = 4,
   parameter int          SEL_W          = 4,
   parameter int          BANK_BASE      = 6,
   parameter int          CACHE_CODE_CNT = 4,
   parameter int          LINK0_CODE     = 6,
   parameter int          LINK1_CODE     = 7,
   parameter int          CFG_AW         = 32,
   parameter int          CFG_DW         = 32,
   parameter logic [31:0] CFG_ADDR       = 32'h3FF0_0400,
   localparam int         BANK_W         = $clog2(NUM_BANKS),
   localparam int         NUM_SLAVES     = NUM_BANKS + 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  req_valid,
   input  logic [ADDR_W-1:0]     req_addr,
   input  logic                  cfg_wr_en,
   input  logic [CFG_AW-1:0]     cfg_addr,
   input  logic [CFG_DW-1:0]     cfg_wdata,
   output logic [CFG_DW-1:0]     cfg_rdata,
   output logic                  route_valid,
   output logic [NUM_SLAVES-1:0] route_sel,
   output logic [BANK_W-1:0]     bank_idx,
   output logic                  decode_err
);
   localparam int LINK0_BIT = NUM_BANKS;
   localparam int LINK1_BIT = NUM_BANKS + 1;
   localparam int TOP_PAIR  = BANK_BASE + BANK_W * (2 ** SEL_W);

   // elaboration-time parameter checks
   generate
      if (NUM_BANKS < 2 || NUM_BANKS != (1 << BANK_W)) begin : g_bad_banks
         $error("NUM_BANKS must be a power of two, at least 2");
      end
      if (TOP_PAIR > ADDR_W - REGION_W) begin : g_bad_pairs
         $error("bank select bits overlap the region field");
      end
      if (CACHE_CODE_CNT > LINK0_CODE || LINK0_CODE == LINK1_CODE ||
          LINK1_CODE >= (1 << REGION_W)) begin : g_bad_codes
         $error("region codes overlap or do not fit");
      end
      if (SEL_W > CFG_DW) begin : g_bad_sel
         $error("select field wider than the register data");
      end
   endgenerate

   logic [SEL_W-1:0]  sel_q;
   dest_e             dest;
   logic [BANK_W-1:0] bank_c;

   arx_sel_reg #(
      .CFG_AW  (CFG_AW),
      .CFG_DW  (CFG_DW),
      .SEL_W   (SEL_W),
      .CFG_ADDR(CFG_ADDR)
   ) u_sel (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(cfg_wr_en),
      .addr (cfg_addr),
      .wdata(cfg_wdata),
      .sel_q(sel_q),
      .rdata(cfg_rdata)
   );

   arx_region_decode #(
      .REGION_W      (REGION_W),
      .CACHE_CODE_CNT(CACHE_CODE_CNT),
      .LINK0_CODE    (LINK0_CODE),
      .LINK1_CODE    (LINK1_CODE)
   ) u_region (
      .region(req_addr[ADDR_W-1 -: REGION_W]),
      .dest  (dest)
   );

   arx_bank_pick #(
      .ADDR_W   (ADDR_W),
      .SEL_W    (SEL_W),
      .BANK_W   (BANK_W),
      .BANK_BASE(BANK_BASE)
   ) u_bank (
      .addr(req_addr),
      .sel (sel_q),
      .bank(bank_c)
   );

   logic [NUM_SLAVES-1:0] sel_c;
   always_comb begin
      sel_c = '0;
      unique case (dest)
         DST_CACHE: sel_c[bank_c]    = 1'b1;
         DST_LINK0: sel_c[LINK0_BIT] = 1'b1;
         DST_LINK1: sel_c[LINK1_BIT] = 1'b1;
         default:   sel_c            = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_valid <= 1'b0;
         route_sel   <= '0;
         bank_idx    <= '0;
         decode_err  <= 1'b0;
      end else begin
         route_valid <= req_valid && (dest != DST_NONE);
         decode_err  <= req_valid && (dest == DST_NONE);
         route_sel   <= req_valid ? sel_c : '0;
         bank_idx    <= (req_valid && dest == DST_CACHE) ? bank_c : '0;
      end
   end
endmodule

// File: rtl/arx_route_chk.sv
module arx_route_chk #(
   parameter int          ADDR_W         = 44,
   parameter int          REGION_W       = 3,
   parameter int          NUM_BANKS      = 4,
   parameter int          SEL_W          = 4,
   parameter int          BANK_BASE      = 6,
   parameter int          CACHE_CODE_CNT = 4,
   parameter int          LINK0_CODE     = 6,
   parameter int          LINK1_CODE     = 7,
   parameter int          CFG_AW         = 32,
   parameter int          CFG_DW         = 32,
   parameter logic [31:0] CFG_ADDR       = 32'h3FF0_0400,
   localparam int         BANK_W         = $clog2(NUM_BANKS),
   localparam int         NUM_SLAVES     = NUM_BANKS + 2
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  req_valid,
   input logic [ADDR_W-1:0]     req_addr,
   input logic                  cfg_wr_en,
   input logic [CFG_AW-1:0]     cfg_addr,
   input logic [CFG_DW-1:0]     cfg_wdata,
   input logic                  route_valid,
   input logic [NUM_SLAVES-1:0] route_sel,
   input logic [BANK_W-1:0]     bank_idx,
   input logic                  decode_err,
   input logic [SEL_W-1:0]      sel_q
);
   logic past_ok;
   always_ff @(posedge clk) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   logic [REGION_W-1:0] region;
   logic                region_none;
   logic                cfg_hit;
   assign region      = req_addr[ADDR_W-1 -: REGION_W];
   assign region_none = (int'(region) >= CACHE_CODE_CNT) &&
                        (int'(region) != LINK0_CODE) && (int'(region) != LINK1_CODE);
   assign cfg_hit     = cfg_wr_en && (cfg_addr == CFG_AW'(CFG_ADDR));

   logic unused_cfg;
   assign unused_cfg = ^cfg_wdata;

   // R2
   route_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      route_valid |-> $countones(route_sel) == 1);

   // R2
   bank_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_valid && (route_sel[NUM_BANKS-1:0] != '0)) |-> route_sel[bank_idx]);

   // R3
   link_bank_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (route_sel[NUM_SLAVES-1:NUM_BANKS] != '0) |-> bank_idx == '0);

   // R4
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      decode_err |-> (!route_valid && route_sel == '0));

   // R4
   err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(req_valid && region_none)) |-> decode_err);

   // R5
   bank_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && route_valid && (route_sel[NUM_BANKS-1:0] != '0)) |->
         bank_idx == BANK_W'($past(req_addr) >> (BANK_BASE + BANK_W * int'($past(sel_q)))));

   // R6
   sel_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && $past(cfg_hit)) |-> sel_q == $past(cfg_wdata[SEL_W-1:0]));

   // R7
   sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(cfg_hit)) |-> $stable(sel_q));

   // R8
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(req_valid)) |-> (!route_valid && !decode_err && route_sel == '0));
endmodule

bind addr_route_xbar arx_route_chk #(
   .ADDR_W        (ADDR_W),
   .REGION_W      (REGION_W),
   .NUM_BANKS     (NUM_BANKS),
   .SEL_W         (SEL_W),
   .BANK_BASE     (BANK_BASE),
   .CACHE_CODE_CNT(CACHE_CODE_CNT),
   .LINK0_CODE    (LINK0_CODE),
   .LINK1_CODE    (LINK1_CODE),
   .CFG_AW        (CFG_AW),
   .CFG_DW        (CFG_DW),
   .CFG_ADDR      (CFG_ADDR)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_addr   (req_addr),
   .cfg_wr_en  (cfg_wr_en),
   .cfg_addr   (cfg_addr),
   .cfg_wdata  (cfg_wdata),
   .route_valid(route_valid),
   .route_sel  (route_sel),
   .bank_idx   (bank_idx),
   .decode_err (decode_err),
   .sel_q      (sel_q)
);

// File: tb/tb_addr_route_xbar.sv
`timescale 1ns/1ps
module tb_addr_route_xbar;
   localparam logic [31:0] CFG = 32'h3FF0_0400;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [43:0] req_addr = '0;
   logic        cfg_wr_en = 1'b0;
   logic [31:0] cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        route_valid;
   logic [5:0]  route_sel;
   logic [1:0]  bank_idx;
   logic        decode_err;

   int tests = 0;
   int fails = 0;
   int msel  = 0;
   bit done  = 1'b0;

   always #2 clk = ~clk;

   addr_route_xbar dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .route_valid(route_valid), .route_sel(route_sel),
      .bank_idx(bank_idx), .decode_err(decode_err)
   );

   task automatic check_out(input string tag, input bit ev, input logic [5:0] es,
                            input logic [1:0] eb, input bit ee);
      tests++;
      if (route_valid !== ev || route_sel !== es || bank_idx !== eb || decode_err !== ee) begin
         fails++;
         $display("FAIL %s: got v=%0b sel=%b bank=%0d err=%0b, expected v=%0b sel=%b bank=%0d err=%0b",
                  tag, route_valid, route_sel, bank_idx, decode_err, ev, es, eb, ee);
      end
   endtask

   // one clock: drive, let the model decide on the edge, compare at the falling edge
   task automatic step(input bit rv, input logic [43:0] a, input bit we,
                       input logic [31:0] wa, input logic [31:0] wd, input string tag);
      bit ev, ee;
      logic [5:0] es;
      logic [1:0] eb;
      int region;
      req_valid = rv; req_addr = a; cfg_wr_en = we; cfg_addr = wa; cfg_wdata = wd;
      @(posedge clk);
      ev = 0; ee = 0; es = '0; eb = '0;
      region = int'(a[43:41]);
      if (rv) begin
         if (region < 4) begin
            eb = 2'((a >> (6 + 2*msel)) & 44'd3);
            es = 6'(1) << eb;
            ev = 1;
         end else if (region == 6) begin
            es = 6'b01_0000; ev = 1;
         end else if (region == 7) begin
            es = 6'b10_0000; ev = 1;
         end else begin
            ee = 1;
         end
      end
      if (we && wa == CFG) msel = int'(wd[3:0]);
      @(negedge clk);
      req_valid = 0; cfg_wr_en = 0;
      check_out(tag, ev, es, eb, ee);
   endtask

   task automatic rd_chk(input logic [31:0] a, input string tag);
      logic [31:0] exp;
      cfg_addr = a;
      #1;
      exp = (a == CFG) ? 32'(msel) : 32'd0;
      tests++;
      if (cfg_rdata !== exp) begin
         fails++;
         $display("FAIL %s: cfg_rdata got %h expected %h", tag, cfg_rdata, exp);
      end
   endtask

   // address in region r with a distinct value in every candidate bit pair
   function automatic logic [43:0] mk(input int r, input logic [31:0] pairs);
      return {3'(r), 3'b000, pairs, 6'b0};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      logic [63:0] rnd;
      repeat (3) @(negedge clk);
      check_out("R1 in reset", 0, '0, '0, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check_out("R1 after reset", 0, '0, '0, 0);
      rd_chk(CFG, "R1 select reads 0");

      step(0, mk(6, 32'hFFFF_FFFF), 0, '0, '0, "R8 idle cycle");
      // R5 default pair [7:6]
      for (int b = 0; b < 4; b++)
         step(1, mk(b, 32'h1B1B_1B1B ^ 32'(b)), 0, '0, '0, "R2 R5 cache default pair");
      step(1, mk(6, 32'h3), 0, '0, '0, "R3 link0");
      step(1, mk(7, 32'h2), 0, '0, '0, "R3 link1");
      step(1, mk(4, 32'h1), 0, '0, '0, "R4 region 4");
      step(0, '0, 0, '0, '0, "R4 err pulse ends");
      step(1, mk(5, 32'h2), 0, '0, '0, "R4 region 5");
      step(1, mk(4, 32'h0), 0, '0, '0, "R4 back to back error");

      // R6 write with same-cycle request uses the old select
      step(1, mk(1, 32'hE4E4_E4E4), 1, CFG, 32'h5, "R6 same cycle old select");
      step(1, mk(1, 32'hE4E4_E4E4), 0, '0, '0, "R6 new select applies");
      rd_chk(CFG, "R7 readback after write");
      // R7 upper bits dropped, wrong address ignored
      step(0, '0, 1, CFG, 32'hABCD_0012, "R7 upper write bits dropped");
      rd_chk(CFG, "R7 low nibble kept");
      step(1, mk(2, 32'h0000_0030), 0, '0, '0, "R7 select 2 pair [11:10]");
      step(0, '0, 1, CFG + 32'd4, 32'h9, "R7 other address write");
      step(1, mk(3, 32'h0000_0030), 0, '0, '0, "R7 ignored write keeps select");
      rd_chk(CFG + 32'd4, "R7 other address reads 0");
      // R5 highest pair [37:36]
      step(0, '0, 1, CFG, 32'hF, "R5 program select 15");
      step(1, mk(0, 32'h8000_0000), 0, '0, '0, "R5 pair [37:36] value 2");
      step(1, mk(3, 32'hC000_0000), 0, '0, '0, "R5 pair [37:36] value 3");
      step(1, mk(7, 32'hC000_0000), 0, '0, '0, "R3 link bank is 0");

      // mixed traffic with occasional reprogramming
      for (int i = 0; i < 400; i++) begin
         rnd = {$urandom(), $urandom()};
         if ((i % 13) == 0)
            step(rnd[0], rnd[43:0], 1, ((i % 3) == 0) ? CFG + 32'd8 : CFG, $urandom(), "R5 R6 R7 mixed");
         else
            step(rnd[63], rnd[43:0], 0, '0, '0, "R2 R3 R4 R8 mixed");
      end
      rd_chk(CFG, "R7 final readback");

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule